// File: doc/BRIEF.md
# Colour standard search controller

This block picks the colour standard and the crystal reference that a multistandard colour decoder should try. It walks an ordered list of five candidates (a standard paired with a crystal), once per field strobe. It skips every candidate that the declared crystal fit or the force setting rules out. It stops on a candidate once the demodulator's identification flag for that standard confirms it. After that it tracks loss of identification and restarts the search when identification stays absent.

The selected standard and crystal drive the demodulators directly, both while a candidate is on trial and once one is latched. A colour-kill flag and a 3-bit readout code report the result to the rest of the chip. Force inputs can restrict the search to one family of standards on one crystal. One force combination is flagged as illegal.

Top module: `colour_std_search`

## Requirements
- R1: After reset the controller tries PAL on the reference crystal (std_sel_o = 00, xtal_ref_o = 1), with colour_kill_o = 1 and readout_o = 110.
- R2: The candidate order is PAL/reference, PAL/second, NTSC/reference, NTSC/second, SECAM/reference, and it wraps around. A candidate on trial is held for HOLD_FIELDS step strobes without confirmation and then gives way to the next allowed candidate. Without a strobe, the state does not change.
- R3: xtal_cfg_i[0] = 1 declares a second crystal. When it is 0, only one crystal is fitted, the second-crystal candidates are skipped, and every trial uses the reference crystal.
- R4: xtal_cfg_i[1] = 1 declares that the reference crystal is the 4.4 MHz one. SECAM is tried only when this bit is set, and always on the reference crystal.
- R5: The force inputs select the mode {force_en_i, force_secam_i, force_ref_i}: 0xx = automatic search, 100 = PAL/NTSC on the second crystal, 101 = PAL/NTSC on the reference crystal, 111 = SECAM on the reference crystal. If a change of these inputs makes the current candidate disallowed, the latch is dropped and the first allowed candidate in order is taken on the next clock.
- R6: A strobe that arrives while the flag for the current candidate's standard is high latches that candidate. This also holds on the strobe that would otherwise end its dwell. From the next cycle colour_kill_o = 0.
- R7: PAL wins over SECAM: a SECAM candidate is not confirmed on a strobe where pal_id_i is also high.
- R8: While a candidate is latched, HOLD_FIELDS consecutive strobes without its flag drop the latch and restart the search at the first allowed candidate in order.
- R9: While latched, readout_o reads 000 for PAL/second, 001 for PAL/reference, 010 for NTSC/second, 011 for NTSC/reference and 101 for SECAM/reference. With colour off it reads 110. std_sel_o encodes 00 PAL, 01 NTSC, 10 SECAM.
- R10: Force mode 110 gives readout_o = 100 with colour killed. A forced mode for which no candidate is allowed (for example the second crystal with one crystal fitted) keeps colour killed with readout 110. No identification flag can latch in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_step_i | input | 1 | One-cycle strobe per field |
| pal_id_i | input | 1 | PAL identified on the current trial |
| ntsc_id_i | input | 1 | NTSC identified on the current trial |
| secam_id_i | input | 1 | SECAM identified on the current trial |
| xtal_cfg_i | input | 2 | [0] second crystal fitted, [1] reference crystal is 4.4 MHz |
| force_en_i | input | 1 | Force mode enable |
| force_secam_i | input | 1 | Force SECAM family |
| force_ref_i | input | 1 | Force reference crystal |
| std_sel_o | output | 2 | Standard under trial or latched |
| xtal_ref_o | output | 1 | 1 = reference crystal, 0 = second crystal |
| colour_kill_o | output | 1 | High whenever no candidate is latched |
| readout_o | output | 3 | Status code |

## Verification
Two collisions are provoked. In the first, the strobe that ends a candidate's dwell also carries that candidate's identification flag: it is driven on the fourth strobe of the PAL/reference trial, and the block is judged correct if it latches with code 001 rather than moving on to PAL/second. In the second, PAL and SECAM flags rise on the same strobe during the SECAM trial. The result must stay killed, and a later strobe with only the SECAM flag must latch code 101. A force change arriving while a candidate is latched is also checked: it must drop the latch on the next clock.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        STD_PAL   = 2'd0,
        STD_NTSC  = 2'd1,
        STD_SECAM = 2'd2
    } std_e;

    localparam int NUM_CAND = 5;
    localparam int CAND_W   = 3;

    localparam int CFG_SECOND_BIT = 0;
    localparam int CFG_REF44_BIT  = 1;

    localparam logic [2:0] CODE_ILLEGAL = 3'b100;
    localparam logic [2:0] CODE_OFF     = 3'b110;

    // Candidate order: 0 PAL/ref, 1 PAL/second, 2 NTSC/ref, 3 NTSC/second, 4 SECAM/ref
    function automatic std_e cand_std(input logic [CAND_W-1:0] c);
        case (c)
            3'd0, 3'd1: cand_std = STD_PAL;
            3'd2, 3'd3: cand_std = STD_NTSC;
            default:    cand_std = STD_SECAM;
        endcase
    endfunction

    function automatic logic cand_ref(input logic [CAND_W-1:0] c);
        cand_ref = (c == 3'd0) || (c == 3'd2) || (c == 3'd4);
    endfunction

    function automatic logic [2:0] cand_code(input logic [CAND_W-1:0] c);
        case (c)
            3'd0:    cand_code = 3'b001;
            3'd1:    cand_code = 3'b000;
            3'd2:    cand_code = 3'b011;
            3'd3:    cand_code = 3'b010;
            3'd4:    cand_code = 3'b101;
            default: cand_code = CODE_OFF;
        endcase
    endfunction

endpackage

// File: rtl/csc_legal.sv
module csc_legal
    import csc_pkg::*;
(
    input  logic [1:0]          xtal_cfg_i,
    input  logic                force_en_i,
    input  logic                force_secam_i,
    input  logic                force_ref_i,
    output logic [NUM_CAND-1:0] legal_o,
    output logic                force_bad_o
);

    assign force_bad_o = force_en_i && force_secam_i && !force_ref_i;

    for (genvar g = 0; g < NUM_CAND; g++) begin : g_cand
        localparam logic [CAND_W-1:0] IDX = CAND_W'(g);
        logic fit_ok;
        logic force_ok;

        always_comb begin
            fit_ok = cand_ref(IDX) ? 1'b1 : xtal_cfg_i[CFG_SECOND_BIT];
            if (cand_std(IDX) == STD_SECAM) begin
                fit_ok = fit_ok && xtal_cfg_i[CFG_REF44_BIT];
            end
            if (!force_en_i) begin
                force_ok = 1'b1;
            end else if (force_secam_i) begin
                force_ok = force_ref_i && (cand_std(IDX) == STD_SECAM);
            end else begin
                force_ok = (cand_std(IDX) != STD_SECAM) && (cand_ref(IDX) == force_ref_i);
            end
            legal_o[g] = fit_ok && force_ok;
        end
    end

endmodule

// File: rtl/csc_pick.sv
module csc_pick #(
    parameter int NUM = 5,
    parameter int W   = 3
) (
    input  logic [NUM-1:0] legal_i,
    input  logic [W-1:0]   start_i,
    output logic [W-1:0]   idx_o,
    output logic           found_o
);

    always_comb begin
        idx_o   = start_i;
        found_o = 1'b0;
        for (int off = NUM - 1; off >= 0; off--) begin
            int pos;
            pos = int'(start_i) + off;
            if (pos >= NUM) pos = pos - NUM;
            if (legal_i[pos]) begin
                idx_o   = W'(pos);
                found_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/csc_fsm.sv
module csc_fsm
    import csc_pkg::*;
#(
    parameter int HOLD_FIELDS = 4,
    parameter int CNT_W       = $clog2(HOLD_FIELDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic                pal_id_i,
    input  logic                ntsc_id_i,
    input  logic                secam_id_i,
    input  logic [NUM_CAND-1:0] legal_i,
    input  logic [CAND_W-1:0]   next_idx_i,
    input  logic                next_found_i,
    input  logic [CAND_W-1:0]   first_idx_i,
    input  logic                first_found_i,
    output logic [CAND_W-1:0]   idx_o,
    output logic                locked_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_FIELDS - 1);

    typedef struct packed {
        logic [CAND_W-1:0] idx;
        logic              locked;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t state_d, state_q;
    logic   cur_legal;
    logic   hit;

    always_comb begin
        cur_legal = legal_i[state_q.idx];
        case (cand_std(state_q.idx))
            STD_PAL:  hit = pal_id_i;
            STD_NTSC: hit = ntsc_id_i;
            default:  hit = secam_id_i && !pal_id_i;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (!cur_legal) begin
            state_d.locked = 1'b0;
            state_d.cnt    = '0;
            if (first_found_i) state_d.idx = first_idx_i;
        end else if (step_i) begin
            if (hit) begin
                state_d.locked = 1'b1;
                state_d.cnt    = '0;
            end else if (state_q.cnt == CNT_LAST) begin
                state_d.cnt = '0;
                if (state_q.locked) begin
                    state_d.locked = 1'b0;
                    state_d.idx    = first_idx_i;
                end else if (next_found_i) begin
                    state_d.idx = next_idx_i;
                end
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign idx_o    = state_q.idx;
    assign locked_o = state_q.locked;

    // R2: without a strobe, an allowed candidate keeps its whole state
    p_no_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && cur_legal) |=> $stable(state_q));

    // R8: a latched candidate that keeps its flag stays latched
    p_hit_keeps_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.locked && step_i && hit && cur_legal) |=> state_q.locked);

endmodule

// File: rtl/colour_std_search.sv
module colour_std_search
    import csc_pkg::*;
#(
    parameter int HOLD_FIELDS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_step_i,
    input  logic       pal_id_i,
    input  logic       ntsc_id_i,
    input  logic       secam_id_i,
    input  logic [1:0] xtal_cfg_i,
    input  logic       force_en_i,
    input  logic       force_secam_i,
    input  logic       force_ref_i,
    output logic [1:0] std_sel_o,
    output logic       xtal_ref_o,
    output logic       colour_kill_o,
    output logic [2:0] readout_o
);

    logic [NUM_CAND-1:0] legal;
    logic                force_bad;
    logic [CAND_W-1:0]   cur_idx;
    logic [CAND_W-1:0]   after_idx;
    logic [CAND_W-1:0]   next_idx;
    logic [CAND_W-1:0]   first_idx;
    logic                next_found;
    logic                first_found;
    logic                locked;

    csc_legal u_legal (
        .xtal_cfg_i    (xtal_cfg_i),
        .force_en_i    (force_en_i),
        .force_secam_i (force_secam_i),
        .force_ref_i   (force_ref_i),
        .legal_o       (legal),
        .force_bad_o   (force_bad)
    );

    assign after_idx = (cur_idx == CAND_W'(NUM_CAND - 1)) ? '0 : cur_idx + 1'b1;

    csc_pick #(.NUM(NUM_CAND), .W(CAND_W)) u_pick_next (
        .legal_i (legal),
        .start_i (after_idx),
        .idx_o   (next_idx),
        .found_o (next_found)
    );

    csc_pick #(.NUM(NUM_CAND), .W(CAND_W)) u_pick_first (
        .legal_i (legal),
        .start_i ('0),
        .idx_o   (first_idx),
        .found_o (first_found)
    );

    csc_fsm #(.HOLD_FIELDS(HOLD_FIELDS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .step_i        (field_step_i),
        .pal_id_i      (pal_id_i),
        .ntsc_id_i     (ntsc_id_i),
        .secam_id_i    (secam_id_i),
        .legal_i       (legal),
        .next_idx_i    (next_idx),
        .next_found_i  (next_found),
        .first_idx_i   (first_idx),
        .first_found_i (first_found),
        .idx_o         (cur_idx),
        .locked_o      (locked)
    );

    always_comb begin
        std_sel_o     = cand_std(cur_idx);
        xtal_ref_o    = cand_ref(cur_idx);
        colour_kill_o = !locked;
        if (force_bad)   readout_o = CODE_ILLEGAL;
        else if (!locked) readout_o = CODE_OFF;
        else             readout_o = cand_code(cur_idx);
    end

    // R3: a latched second-crystal candidate implies a declared second crystal
    p_second_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!colour_kill_o && !xtal_ref_o) |-> $past(xtal_cfg_i[0]));

    // R4: a latched SECAM candidate implies the 4.4 MHz reference
    p_secam_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!colour_kill_o && std_sel_o == 2'd2) |-> ($past(xtal_cfg_i[1]) && xtal_ref_o));

    // R6: colour is only switched on by a strobe
    p_lock_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(colour_kill_o) |-> $past(field_step_i));

    // R9: while colour is off the readout is in its upper half
    p_kill_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        colour_kill_o |-> readout_o[2]);

    // R10: the illegal force code never coexists with colour on
    p_illegal_killed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (readout_o == 3'b100) |-> colour_kill_o);

endmodule

// File: tb/colour_std_search_tb.sv
module colour_std_search_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic       pal = 1'b0, ntsc = 1'b0, secam = 1'b0;
    logic [1:0] cfg = 2'b11;
    logic       fen = 1'b0, fsec = 1'b0, fref = 1'b0;
    logic [1:0] std_sel;
    logic       xref, kill;
    logic [2:0] code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    colour_std_search #(.HOLD_FIELDS(4)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .field_step_i  (step),
        .pal_id_i      (pal),
        .ntsc_id_i     (ntsc),
        .secam_id_i    (secam),
        .xtal_cfg_i    (cfg),
        .force_en_i    (fen),
        .force_secam_i (fsec),
        .force_ref_i   (fref),
        .std_sel_o     (std_sel),
        .xtal_ref_o    (xref),
        .colour_kill_o (kill),
        .readout_o     (code)
    );

    task automatic expect_all(input string req, input logic [1:0] e_std, input logic e_ref,
                              input logic e_kill, input logic [2:0] e_code);
        checks++;
        if (std_sel !== e_std || xref !== e_ref || kill !== e_kill || code !== e_code) begin
            fails++;
            $display("FAIL %s: got std=%b ref=%b kill=%b code=%b, expected std=%b ref=%b kill=%b code=%b",
                     req, std_sel, xref, kill, code, e_std, e_ref, e_kill, e_code);
        end
    endtask

    task automatic expect_status(input string req, input logic e_kill, input logic [2:0] e_code);
        checks++;
        if (kill !== e_kill || code !== e_code) begin
            fails++;
            $display("FAIL %s: got kill=%b code=%b, expected kill=%b code=%b",
                     req, kill, code, e_kill, e_code);
        end
    endtask

    task automatic do_reset(input logic [1:0] c, input logic e, input logic s, input logic r);
        @(negedge clk);
        rst_n = 1'b0;
        step = 1'b0; pal = 1'b0; ntsc = 1'b0; secam = 1'b0;
        cfg = c; fen = e; fsec = s; fref = r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step = 1'b1;
            @(negedge clk);
            step = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        do_reset(2'b11, 1'b0, 1'b0, 1'b0);
        expect_all("R1 reset", 2'd0, 1'b1, 1'b1, 3'b110);
        repeat (5) @(negedge clk);
        expect_all("R2 no strobe no change", 2'd0, 1'b1, 1'b1, 3'b110);
    endtask

    task automatic t_full_order();
        do_reset(2'b11, 1'b0, 1'b0, 1'b0);
        steps(3);
        expect_all("R2 dwell not over", 2'd0, 1'b1, 1'b1, 3'b110);
        steps(1);
        expect_all("R2 PAL second", 2'd0, 1'b0, 1'b1, 3'b110);
        steps(4);
        expect_all("R2 NTSC ref", 2'd1, 1'b1, 1'b1, 3'b110);
        steps(4);
        expect_all("R2 NTSC second", 2'd1, 1'b0, 1'b1, 3'b110);
        steps(4);
        expect_all("R2 SECAM ref", 2'd2, 1'b1, 1'b1, 3'b110);
        steps(4);
        expect_all("R2 wrap", 2'd0, 1'b1, 1'b1, 3'b110);
    endtask

    task automatic t_one_crystal();
        do_reset(2'b10, 1'b0, 1'b0, 1'b0);
        steps(4);
        expect_all("R3 skip second, NTSC ref", 2'd1, 1'b1, 1'b1, 3'b110);
        steps(4);
        expect_all("R4 SECAM with 4.4 ref", 2'd2, 1'b1, 1'b1, 3'b110);
        steps(4);
        expect_all("R3 wrap to PAL ref", 2'd0, 1'b1, 1'b1, 3'b110);
        do_reset(2'b00, 1'b0, 1'b0, 1'b0);
        steps(4);
        expect_all("R3 3.6 only NTSC ref", 2'd1, 1'b1, 1'b1, 3'b110);
        steps(4);
        expect_all("R4 no SECAM without 4.4", 2'd0, 1'b1, 1'b1, 3'b110);
    endtask

    task automatic t_lock_race_and_loss();
        do_reset(2'b11, 1'b0, 1'b0, 1'b0);
        steps(3);
        pal = 1'b1;
        steps(1);
        expect_all("R6 lock on dwell-ending strobe", 2'd0, 1'b1, 1'b0, 3'b001);
        steps(2);
        expect_all("R6 lock held with flag", 2'd0, 1'b1, 1'b0, 3'b001);
        pal = 1'b0;
        steps(3);
        expect_all("R8 lock survives 3 misses", 2'd0, 1'b1, 1'b0, 3'b001);
        steps(1);
        expect_all("R8 lock lost", 2'd0, 1'b1, 1'b1, 3'b110);
    endtask

    task automatic t_loss_restart();
        do_reset(2'b11, 1'b0, 1'b0, 1'b0);
        steps(12);
        ntsc = 1'b1;
        steps(1);
        expect_all("R9 NTSC second code", 2'd1, 1'b0, 1'b0, 3'b010);
        ntsc = 1'b0;
        steps(4);
        expect_all("R8 restart at PAL ref", 2'd0, 1'b1, 1'b1, 3'b110);
    endtask

    task automatic t_pal_priority();
        do_reset(2'b11, 1'b0, 1'b0, 1'b0);
        steps(16);
        pal = 1'b1; secam = 1'b1;
        steps(1);
        expect_all("R7 SECAM not confirmed with PAL", 2'd2, 1'b1, 1'b1, 3'b110);
        pal = 1'b0;
        steps(1);
        expect_all("R9 SECAM code", 2'd2, 1'b1, 1'b0, 3'b101);
        secam = 1'b0;
    endtask

    task automatic t_forced();
        do_reset(2'b11, 1'b1, 1'b0, 1'b0);
        expect_all("R5 forced second starts PAL second", 2'd0, 1'b0, 1'b1, 3'b110);
        steps(4);
        expect_all("R5 forced second NTSC second", 2'd1, 1'b0, 1'b1, 3'b110);
        steps(4);
        expect_all("R5 forced second wraps", 2'd0, 1'b0, 1'b1, 3'b110);
        pal = 1'b1;
        steps(1);
        pal = 1'b0;
        expect_all("R9 PAL second code", 2'd0, 1'b0, 1'b0, 3'b000);
        fref = 1'b1;
        @(negedge clk);
        expect_all("R5 force change drops lock", 2'd0, 1'b1, 1'b1, 3'b110);
        steps(4);
        expect_all("R5 forced ref NTSC ref", 2'd1, 1'b1, 1'b1, 3'b110);
        ntsc = 1'b1;
        steps(1);
        ntsc = 1'b0;
        expect_all("R9 NTSC ref code", 2'd1, 1'b1, 1'b0, 3'b011);
        do_reset(2'b11, 1'b1, 1'b1, 1'b1);
        expect_all("R5 forced SECAM", 2'd2, 1'b1, 1'b1, 3'b110);
        secam = 1'b1;
        steps(1);
        secam = 1'b0;
        expect_all("R5 forced SECAM lock", 2'd2, 1'b1, 1'b0, 3'b101);
    endtask

    task automatic t_no_candidate();
        do_reset(2'b11, 1'b1, 1'b1, 1'b0);
        expect_status("R10 illegal force code", 1'b1, 3'b100);
        pal = 1'b1; ntsc = 1'b1; secam = 1'b1;
        steps(5);
        expect_status("R10 illegal force ignores flags", 1'b1, 3'b100);
        do_reset(2'b10, 1'b1, 1'b0, 1'b0);
        expect_status("R10 second forced, one crystal", 1'b1, 3'b110);
        pal = 1'b1; ntsc = 1'b1;
        steps(5);
        expect_status("R10 no lock without candidate", 1'b1, 3'b110);
        pal = 1'b0; ntsc = 1'b0; secam = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_full_order();
        t_one_crystal();
        t_lock_race_and_loss();
        t_loss_restart();
        t_pal_priority();
        t_forced();
        t_no_candidate();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule